// File: doc/BRIEF.md
# Extend, Quick-Load and Saturate Move Unit

This unit is the execute stage for a small family of single-operand data moves in a 32-bit integer pipeline. In one clock it can widen a byte or halfword to a full word, either by copying the sign or by filling with zeros. It can also expand a 3-bit short constant to a full word, clamp a register to the signed extreme when the incoming overflow flag is set, or form the value that a test-and-set writes back to memory. Operand fetch and the locked read-modify-write bus cycle belong to the surrounding pipeline. This unit only sees the operand value and produces the new value.

Each cycle the pipeline presents an operation code, a size bit, the operand, the short constant and the current overflow flag. One cycle later the unit presents the result, a register/memory write enable and new negative, zero, overflow and carry flags. The extend flag is never touched by these operations, so it has no port here.

Top module: `xmov_unit`

## Requirements
- R1: Operation code 0 (sign extend): with size bit 0, bit 7 of the operand fills bits 31:8; with size bit 1, bit 15 fills bits 31:16. Flags N and Z follow the 32-bit result.
- R2: Operation code 1 (zero fill): with size bit 0, bits 7:0 are kept; with size bit 1, bits 15:0 are kept. All higher bits are cleared. N is always 0 and Z is set when the 32-bit result is zero.
- R3: Operation code 2 (quick load): codes 1 to 7 give that value zero-extended to 32 bits, and code 0 gives FFFFFFFFh. The size bit has no effect.
- R4: Operation code 3 (saturate) with incoming V = 1: the result is 80000000h when operand bit 31 is 0, and 7FFFFFFFh when it is 1. Write enable is 1. The size bit has no effect.
- R5: Operation code 3 with incoming V = 0: the result equals the operand and write enable is 0. N and Z are still updated from that unchanged value.
- R6: For operation codes 0 to 3, N is result bit 31 (except where R2 forces 0) and Z is set when the result is zero. V and C are 0 after every operation.
- R7: Operation code 4 (test-and-set): the result is the operand with bit 7 forced to 1 and all other bits unchanged. N is the operand's original bit 7 and Z is set when the original bits 7:0 are zero. Write enable is 1.
- R8: Operation codes 5, 6 and 7 are reserved. They give result 0, write enable 0 and all flags 0.
- R9: All outputs are registered. Inputs sampled at a rising edge appear after that edge. While rst_n is low, all outputs are 0.
- R10: Write enable is 1 for operation codes 0, 1, 2 and 4, and for code 3 when V = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (0 sign extend, 1 zero fill, 2 quick, 3 saturate, 4 test-and-set) |
| size_word | input | 1 | 0 = byte, 1 = halfword; used by codes 0 and 1 only |
| src_val | input | 32 | Operand or register value |
| quick_code | input | 3 | Short constant field, 0 meaning minus one |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Value to write |
| wr_en | output | 1 | Write enable for result |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_v | output | 1 | New overflow flag |
| flag_c | output | 1 | New carry flag |

## Verification
The clocked properties compare each registered output with the inputs seen one edge earlier. They therefore assume that the op code, size bit, operand and overflow flag are driven to known values in every cycle after reset, not only when a real operation is issued. The stimulus keeps to this: it draws every field from a seeded generator on every cycle, reserved op codes 5 to 7 included. It also drives inputs only on falling edges, so no input changes at the sampling edge. The directed cases cover the values at the field boundaries: sign bits set and clear, an all-zero byte, the zero quick code, and saturation of zero and of both signs.

// File: rtl/xmov_pkg.sv
package xmov_pkg;
   typedef enum logic [2:0] {
      XOP_SEXT  = 3'd0,
      XOP_ZFILL = 3'd1,
      XOP_QUICK = 3'd2,
      XOP_SAT   = 3'd3,
      XOP_TAS   = 3'd4
   } xmov_op_e;
endpackage

// File: rtl/xmov_extend.sv
module xmov_extend #(
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int HALF_W    = 16,
   parameter bit ZERO_FILL = 1'b0
) (
   input  logic              size_word,
   input  logic [DATA_W-1:0] src_val,
   output logic [DATA_W-1:0] ext_res,
   output logic              ext_n,
   output logic              ext_z
);
   localparam int BYTE_PAD = DATA_W - BYTE_W;
   localparam int HALF_PAD = DATA_W - HALF_W;

   if (BYTE_W >= HALF_W || HALF_W >= DATA_W) begin : g_bad_widths
      $error("xmov_extend: need BYTE_W < HALF_W < DATA_W");
   end

   logic [BYTE_PAD-1:0] byte_fill;
   logic [HALF_PAD-1:0] half_fill;

   if (ZERO_FILL) begin : g_zero
      assign byte_fill = '0;
      assign half_fill = '0;
      assign ext_n     = 1'b0;
   end else begin : g_sign
      assign byte_fill = {BYTE_PAD{src_val[BYTE_W-1]}};
      assign half_fill = {HALF_PAD{src_val[HALF_W-1]}};
      assign ext_n     = ext_res[DATA_W-1];
   end

   always_comb begin
      if (size_word) ext_res = {half_fill, src_val[HALF_W-1:0]};
      else           ext_res = {byte_fill, src_val[BYTE_W-1:0]};
   end

   assign ext_z = (ext_res == '0);
endmodule

// File: rtl/xmov_quick_sat.sv
module xmov_quick_sat #(
   parameter int DATA_W  = 32,
   parameter int QUICK_W = 3
) (
   input  logic [QUICK_W-1:0] quick_code,
   input  logic [DATA_W-1:0]  src_val,
   input  logic               v_in,
   output logic [DATA_W-1:0]  quick_res,
   output logic [DATA_W-1:0]  sat_res,
   output logic               sat_wr
);
   localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   if (QUICK_W >= DATA_W) begin : g_bad_quick
      $error("xmov_quick_sat: QUICK_W must be below DATA_W");
   end

   always_comb begin
      if (quick_code == '0) quick_res = '1;
      else                  quick_res = DATA_W'(quick_code);
   end

   always_comb begin
      if (!v_in)                   sat_res = src_val;
      else if (src_val[DATA_W-1])  sat_res = MAX_POS;
      else                         sat_res = MAX_NEG;
   end

   assign sat_wr = v_in;
endmodule

// File: rtl/xmov_tas.sv
module xmov_tas #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] src_val,
   output logic [DATA_W-1:0] tas_res,
   output logic              tas_n,
   output logic              tas_z
);
   localparam logic [DATA_W-1:0] LOCK_BIT = DATA_W'(1) << (BYTE_W - 1);

   if (BYTE_W > DATA_W) begin : g_bad_byte
      $error("xmov_tas: BYTE_W exceeds DATA_W");
   end

   assign tas_res = src_val | LOCK_BIT;
   assign tas_n   = src_val[BYTE_W-1];
   assign tas_z   = (src_val[BYTE_W-1:0] == '0);
endmodule

// File: rtl/xmov_unit.sv
module xmov_unit #(
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter int HALF_W  = 16,
   parameter int QUICK_W = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_sel,
   input  logic              size_word,
   input  logic [31:0]       src_val,
   input  logic [2:0]        quick_code,
   input  logic              v_in,
   output logic [31:0]       result,
   output logic              wr_en,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);
   import xmov_pkg::*;

   localparam int MSB = DATA_W - 1;

   if (DATA_W != 32 || QUICK_W != 3) begin : g_bad_port
      $error("xmov_unit: port widths are fixed at 32-bit data and 3-bit quick");
   end

   logic [DATA_W-1:0] sx_res, zf_res, q_res, s_res, t_res;
   logic              sx_n, sx_z, zf_n, zf_z, s_wr, t_n, t_z;

   xmov_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W), .ZERO_FILL(1'b0)) u_sext (
      .size_word(size_word), .src_val(src_val), .ext_res(sx_res), .ext_n(sx_n), .ext_z(sx_z));

   xmov_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W), .ZERO_FILL(1'b1)) u_zfill (
      .size_word(size_word), .src_val(src_val), .ext_res(zf_res), .ext_n(zf_n), .ext_z(zf_z));

   xmov_quick_sat #(.DATA_W(DATA_W), .QUICK_W(QUICK_W)) u_qsat (
      .quick_code(quick_code), .src_val(src_val), .v_in(v_in),
      .quick_res(q_res), .sat_res(s_res), .sat_wr(s_wr));

   xmov_tas #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tas (
      .src_val(src_val), .tas_res(t_res), .tas_n(t_n), .tas_z(t_z));

   logic [DATA_W-1:0] nx_res;
   logic              nx_wr, nx_n, nx_z;

   always_comb begin
      nx_res = '0;
      nx_wr  = 1'b0;
      nx_n   = 1'b0;
      nx_z   = 1'b0;
      case (op_sel)
         XOP_SEXT:  begin nx_res = sx_res; nx_wr = 1'b1; nx_n = sx_n; nx_z = sx_z; end
         XOP_ZFILL: begin nx_res = zf_res; nx_wr = 1'b1; nx_n = zf_n; nx_z = zf_z; end
         XOP_QUICK: begin nx_res = q_res;  nx_wr = 1'b1; nx_n = q_res[MSB]; nx_z = (q_res == '0); end
         XOP_SAT:   begin nx_res = s_res;  nx_wr = s_wr; nx_n = s_res[MSB]; nx_z = (s_res == '0); end
         XOP_TAS:   begin nx_res = t_res;  nx_wr = 1'b1; nx_n = t_n; nx_z = t_z; end
         default:   ;
      endcase
   end

   if (REG_OUT) begin : g_reg
      logic seen_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            seen_q <= 1'b0;
         end else begin
            result <= nx_res;
            wr_en  <= nx_wr;
            flag_n <= nx_n;
            flag_z <= nx_z;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            seen_q <= 1'b1;
         end
      end

      // R1
      sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && $past(op_sel) == 3'd0 && !$past(size_word))
         |-> result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result[BYTE_W-1]}});
      // R2
      zfill_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && $past(op_sel) == 3'd1) |-> (!flag_n && result[DATA_W-1:HALF_W] == '0));
      // R5
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && $past(op_sel) == 3'd3 && !$past(v_in)) |-> (!wr_en && result == $past(src_val)));
      // R6
      vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q |-> (!flag_v && !flag_c));
      // R7
      tas_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && $past(op_sel) == 3'd4)
         |-> (wr_en && result[BYTE_W-1] && flag_n == $past(src_val[BYTE_W-1])));
      // R8
      rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && $past(op_sel) > 3'd4) |-> (!wr_en && result == '0 && !flag_n && !flag_z));
   end else begin : g_comb
      assign result = nx_res;
      assign wr_en  = nx_wr;
      assign flag_n = nx_n;
      assign flag_z = nx_z;
      assign flag_v = 1'b0;
      assign flag_c = 1'b0;
   end
endmodule

// File: tb/xmov_unit_test.sv
module xmov_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        size_word = 1'b0;
   logic [31:0] src_val = '0;
   logic [2:0]  quick_code = '0;
   logic        v_in = 1'b0;
   logic [31:0] result;
   logic        wr_en, flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   xmov_unit uut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .size_word(size_word),
      .src_val(src_val), .quick_code(quick_code), .v_in(v_in),
      .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c));

   // packed as {wr, n, z, v, c, result}
   function automatic logic [36:0] model(input logic [2:0] op, input logic sz,
                                        input logic [31:0] s, input logic [2:0] q,
                                        input logic v);
      logic [31:0] r;
      logic wr, n, z;
      r = 32'h0; wr = 1'b0; n = 1'b0; z = 1'b0;
      case (op)
         3'd0: begin r = sz ? {{16{s[15]}}, s[15:0]} : {{24{s[7]}}, s[7:0]}; wr = 1; n = r[31]; z = (r == 0); end
         3'd1: begin r = sz ? {16'h0, s[15:0]} : {24'h0, s[7:0]}; wr = 1; n = 0; z = (r == 0); end
         3'd2: begin r = (q == 0) ? 32'hFFFF_FFFF : {29'h0, q}; wr = 1; n = r[31]; z = (r == 0); end
         3'd3: begin
            r = !v ? s : (s[31] ? 32'h7FFF_FFFF : 32'h8000_0000);
            wr = v; n = r[31]; z = (r == 0);
         end
         3'd4: begin r = s | 32'h80; wr = 1; n = s[7]; z = (s[7:0] == 0); end
         default: ;
      endcase
      return {wr, n, z, 1'b0, 1'b0, r};
   endfunction

   function automatic string tag_of(input logic [2:0] op, input logic v);
      case (op)
         3'd0: return "R1 R6 R10";
         3'd1: return "R2 R6 R10";
         3'd2: return "R3 R6 R10";
         3'd3: return v ? "R4 R6 R10" : "R5 R6 R10";
         3'd4: return "R7 R10";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got wr/n/z/v/c=%b result=%h, expected wr/n/z/v/c=%b result=%h",
                  tag, got[36:32], got[31:0], exp[36:32], exp[31:0]);
      end
   endtask

   // drive at a falling edge, registered after the next rising edge, sample at the following falling edge
   task automatic apply(input logic [2:0] op, input logic sz, input logic [31:0] s,
                        input logic [2:0] q, input logic v);
      @(negedge clk);
      op_sel = op; size_word = sz; src_val = s; quick_code = q; v_in = v;
      @(negedge clk);
      check(tag_of(op, v), {wr_en, flag_n, flag_z, flag_v, flag_c, result}, model(op, sz, s, q, v));
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      // R9: reset holds every output at zero even with active inputs
      op_sel = 3'd2; quick_code = 3'd5; src_val = 32'hDEAD_BEEF; v_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R9", {wr_en, flag_n, flag_z, flag_v, flag_c, result}, 37'h0);
      rst_n = 1'b1;

      // R1 sign extension, byte and halfword, both signs
      apply(3'd0, 1'b0, 32'h1234_5680, 3'd0, 1'b0);
      apply(3'd0, 1'b0, 32'hFFFF_FF7F, 3'd0, 1'b0);
      apply(3'd0, 1'b1, 32'h0000_8001, 3'd0, 1'b0);
      apply(3'd0, 1'b1, 32'hABCD_0000, 3'd0, 1'b0);
      // R2 zero fill, negative-looking source, zero result
      apply(3'd1, 1'b0, 32'hFFFF_FF80, 3'd0, 1'b0);
      apply(3'd1, 1'b1, 32'h8001_FFFF, 3'd0, 1'b0);
      apply(3'd1, 1'b0, 32'hFFFF_FF00, 3'd0, 1'b1);
      // R3 quick codes, size bit ignored
      apply(3'd2, 1'b0, 32'h0, 3'd0, 1'b0);
      apply(3'd2, 1'b1, 32'hFFFF_FFFF, 3'd7, 1'b1);
      apply(3'd2, 1'b1, 32'h0, 3'd1, 1'b0);
      // R4 and R5 saturation
      apply(3'd3, 1'b0, 32'h0000_0000, 3'd0, 1'b1);
      apply(3'd3, 1'b1, 32'h8000_0001, 3'd0, 1'b1);
      apply(3'd3, 1'b0, 32'h0000_0000, 3'd0, 1'b0);
      apply(3'd3, 1'b0, 32'h9000_0000, 3'd0, 1'b0);
      // R7 test-and-set
      apply(3'd4, 1'b0, 32'h0000_0000, 3'd0, 1'b0);
      apply(3'd4, 1'b1, 32'h5555_5580, 3'd0, 1'b1);
      apply(3'd4, 1'b0, 32'hFFFF_FF01, 3'd0, 1'b0);
      // R8 reserved codes
      apply(3'd5, 1'b1, 32'hFFFF_FFFF, 3'd3, 1'b1);
      apply(3'd7, 1'b0, 32'h0000_0080, 3'd0, 1'b0);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] s;
         s = $urandom;
         if ((i % 5) == 0) s[7:0] = 8'h00;
         apply(3'($urandom % 8), 1'($urandom), s, 3'($urandom), 1'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule